// File: doc/BRIEF.md
# Shadow-Buffered PWM Channel

This block is a single 8-bit pulse-width modulation channel. A free-running up-counter steps through one period at a time. The output level comes from comparing that counter with an active duty value. Software reaches a control byte, a period value, a duty value and the counter through one synchronous write port and one combinational read port.

Period and duty each have two copies. Writes always land in a shadow copy. While the channel runs, the active copy takes the shadow value at only three points: when a period wraps, when the counter is written, and when the channel is switched off. This means a running waveform is always fully old or fully new.

A polarity bit decides what the duty count means. It counts either the high time or the low time at the start of each period.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: Register select values are 0 = control, 1 = period, 2 = duty and 3 = counter. Control bit 0 is the enable and control bit 1 is the polarity. Reading period or duty returns the value most recently written to it, even if the active value differs. Reading control returns {polarity, enable} in bits 1:0, and reading select 3 returns the counter.
- R2: While enabled, the counter goes 0, 1, …, P−1 and then back to 0, where P is the active period. With an active period of 0 the counter stays at 0.
- R3: With polarity 1 and enable 1, the output is high while counter < active duty and low otherwise.
- R4: With polarity 0 and enable 1, the output is low while counter < active duty and high otherwise.
- R5: A duty write while enabled does not change the output until the cycle after the counter wraps. From that cycle on, the new duty applies.
- R6: A period write while enabled does not change the length of the current period. The new period governs from the next period on.
- R7: Any write to the counter select sets the counter to 0 at that clock edge and makes the buffered duty and period active.
- R8: While disabled, the output sits at the inactive level, which is the inverse of the polarity bit. The counter is 0 from the second disabled cycle on. Disabling makes any buffered duty and period active.
- R9: While disabled, a write to period or duty takes effect in the active copy at once, so the first enabled period uses it.
- R10: An active duty of 0, or one at or above the active period, holds the output at one constant level for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | DW | Read data, combinational from rd_addr |
| pwm_out | output | 1 | Channel output |

## Verification
Suppose a commit is lost or happens too early. The output edge then moves in the very next period, or even inside the current one, so every per-cycle output comparison exposes it within one period. A counter that misses its wrap or its clear shows up directly on the counter read-back in the cycle it happens. A shadow copy that is corrupted shows on the period or duty read-back right after the write. A sweep over every polarity, every period from 1 to 12 and every duty from 0 to 14 covers each comparison boundary, including the constant-level cases.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER  = 2'd1,
    SEL_DUTY = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;
  localparam int NUM_SHADOW   = 2;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_val,
  input  logic          pass_thru,
  input  logic          commit,
  output logic [DW-1:0] buf_q,
  output logic [DW-1:0] act_q
);
  logic [DW-1:0] buf_d, act_d;

  always_comb begin
    buf_d = buf_q;
    act_d = act_q;
    if (wr_stb) buf_d = wr_val;
    if (wr_stb && pass_thru) act_d = wr_val;
    else if (commit)         act_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  // R1
  shadow_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> buf_q == $past(wr_val));

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(wr_stb && pass_thru)) |=> $stable(act_q));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [DW-1:0] per_act,
  output logic [DW-1:0] cnt_q,
  output logic          wrap
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};
  logic [DW-1:0] cnt_d;
  logic          per_zero;

  assign per_zero = (per_act == '0);
  assign wrap     = run && (per_zero || (cnt_q >= per_act - ONE));

  always_comb begin
    if (!run || clr || wrap) cnt_d = '0;
    else                     cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !per_zero) |-> cnt_q < per_act);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen #(
  parameter int DW = 8
) (
  input  logic          en,
  input  logic          pol,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] duty_act,
  output logic          out
);
  logic before_match;

  assign before_match = (cnt < duty_act);

  always_comb begin
    if (!en)      out = ~pol;
    else if (pol) out = before_match;
    else          out = ~before_match;
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          pwm_out
);
  localparam int FLD_PER  = 0;
  localparam int FLD_DUTY = 1;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          en_q, pol_q, en_d, pol_d;
  logic          ctrl_wr, cnt_wr, wrap, commit;
  logic [DW-1:0] cnt;
  logic [DW-1:0] fld_buf [NUM_SHADOW];
  logic [DW-1:0] fld_act [NUM_SHADOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign ctrl_wr = wr_en && (wr_addr == SEL_CTRL);
  assign cnt_wr  = wr_en && (wr_addr == SEL_CNT);
  assign commit  = !en_q || wrap || cnt_wr;

  always_comb begin
    en_d  = en_q;
    pol_d = pol_q;
    if (ctrl_wr) begin
      en_d  = wr_data[CTRL_EN_BIT];
      pol_d = wr_data[CTRL_POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      pol_q <= pol_d;
    end
  end

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
    localparam logic [1:0] SEL = (g == FLD_PER) ? SEL_PER : SEL_DUTY;
    logic stb;
    assign stb = wr_en && (wr_addr == SEL);
    pwm_shadow_reg #(.DW(DW)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_stb    (stb),
      .wr_val    (wr_data),
      .pass_thru (!en_q),
      .commit    (commit),
      .buf_q     (fld_buf[g]),
      .act_q     (fld_act[g])
    );
  end

  pwm_counter #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (en_q),
    .clr     (cnt_wr),
    .per_act (fld_act[FLD_PER]),
    .cnt_q   (cnt),
    .wrap    (wrap)
  );

  pwm_outgen #(.DW(DW)) u_out (
    .en       (en_q),
    .pol      (pol_q),
    .cnt      (cnt),
    .duty_act (fld_act[FLD_DUTY]),
    .out      (pwm_out)
  );

  always_comb begin
    unique case (rd_addr)
      SEL_CTRL: rd_data = {{(DW-2){1'b0}}, pol_q, en_q};
      SEL_PER:  rd_data = fld_buf[FLD_PER];
      SEL_DUTY: rd_data = fld_buf[FLD_DUTY];
      default:  rd_data = cnt;
    endcase
  end

  // R7
  cnt_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnt_wr |=> (cnt == '0) && (fld_act[FLD_DUTY] == $past(fld_buf[FLD_DUTY])));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en_q |-> pwm_out == !pol_q);

  // R10
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_q && fld_act[FLD_DUTY] == '0) |-> pwm_out == !pol_q);

  // R3
  period_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_q && pol_q && cnt == '0 && fld_act[FLD_DUTY] != '0) |-> pwm_out);
endmodule

// File: tb/pwm_dbuf_chan_test.sv
module pwm_dbuf_chan_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd3;
  logic [7:0] rd_data;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_dbuf_chan #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // call at a negedge; returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data; rd_addr = 2'd3; #1;
  endtask

  function automatic int exp_out(input int pol, input int k, input int duty);
    int lt = (k < duty) ? 1 : 0;
    return pol ? lt : 1 - lt;
  endfunction

  // checks n cycles of output and counter, starting at counter value k0
  task automatic run_chk(input string tag, input int pol, input int per,
                         input int duty, input int n, input int k0);
    for (int i = 0; i < n; i++) begin
      int k = (per == 0) ? 0 : (k0 + i) % per;
      chk({tag, " out"}, pwm_out, exp_out(pol, k, duty));
      chk("R2 counter", rd_data, k);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state: disabled, polarity 0 -> inactive high
    chk("R8 reset out", pwm_out, 1);
    rd(2'd0, v); chk("R1 reset ctrl", v, 0);
    rd(2'd1, v); chk("R1 reset per", v, 0);
    rd(2'd2, v); chk("R1 reset duty", v, 0);
    chk("R2 reset counter", rd_data, 0);

    // R9 R3 R4 R10: sweep with direct writes while disabled
    for (int pol = 0; pol < 2; pol++)
      for (int per = 1; per <= 12; per++)
        for (int duty = 0; duty <= 14; duty++) begin
          wr(2'd0, 8'(pol << 1));
          wr(2'd1, 8'(per));
          wr(2'd2, 8'(duty));
          wr(2'd0, 8'((pol << 1) | 1));
          run_chk(pol ? "R3 R9 R10" : "R4 R9 R10", pol, per, duty, per + 2, 0);
        end

    // R1 ctrl readback
    rd(2'd0, v); chk("R1 ctrl read", v, 3);

    // R2 period zero holds counter at 0
    wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd2, 8'd3); wr(2'd0, 8'd3);
    run_chk("R2 per0", 1, 0, 3, 5, 0);

    // R5 duty change waits for wrap
    wr(2'd0, 8'd2); wr(2'd1, 8'd8); wr(2'd2, 8'd2); wr(2'd0, 8'd3);
    run_chk("R5 before", 1, 8, 2, 3, 0);
    wr(2'd2, 8'd6);
    rd(2'd2, v); chk("R1 duty readback", v, 6);
    run_chk("R5 old duty", 1, 8, 2, 4, 4);
    run_chk("R5 new duty", 1, 8, 6, 8, 0);

    // R6 period change waits for wrap
    run_chk("R6 before", 1, 8, 6, 2, 0);
    wr(2'd1, 8'd4);
    rd(2'd1, v); chk("R1 per readback", v, 4);
    run_chk("R6 old per", 1, 8, 6, 5, 3);
    run_chk("R6 R10 new per", 1, 4, 6, 8, 0);

    // R7 counter write clears and commits
    wr(2'd0, 8'd0); wr(2'd1, 8'd10); wr(2'd2, 8'd3); wr(2'd0, 8'd1);
    run_chk("R7 before", 0, 10, 3, 2, 0);
    wr(2'd2, 8'd7);
    run_chk("R7 pending", 0, 10, 3, 1, 3);
    wr(2'd3, 8'd0);
    run_chk("R7 after", 0, 10, 7, 10, 0);

    // R8 disable commits buffer, idle level, counter zero
    run_chk("R8 before", 0, 10, 7, 3, 0);
    wr(2'd2, 8'd2);
    wr(2'd0, 8'd0);
    chk("R8 idle out pol0", pwm_out, 1);
    @(negedge clk);
    chk("R8 counter held", rd_data, 0);
    wr(2'd0, 8'd2);
    chk("R8 idle out pol1", pwm_out, 0);
    wr(2'd0, 8'd1);
    run_chk("R8 committed duty", 0, 10, 2, 10, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule